// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block is a hardware state machine that takes a freshly powered or freshly inserted SD or SDHC card from its native state into SPI data mode. It talks to the card through an external byte-wide SPI shifter. The sequencer raises a request with a transmit byte and waits for a done pulse that carries the byte received in the same exchange. The sequencer also drives the card's chip select, active low. A start pulse launches one bring-up run. At the end of the run, exactly one of ready, not-ready or timeout is held until the next start. A further flag tells the data-path logic whether the card takes 512-byte sector numbers or byte offsets as its address.

The run begins with wake-up filler bytes while chip select is high. The sequencer then issues the reset command and the interface-condition probe, which selects the version-1 or version-2 path. It repeats the application-command pair until the card leaves its idle state, reads the operating-conditions register on version-2 cards, and sets a 512-byte block length whenever byte addressing is in force. Each command frame is preceded by one filler byte. Every response is found by polling for the first received byte with its top bit clear.

Top module: `sd_init_seq`

## Requirements
- R1: A start pulse while idle with card_present_i low sets not_ready_o in the next cycle, starts no byte transfer and keeps card_sel_no high.
- R2: A run with a card present begins with WAKE_BYTES (default 16) transfers of 0xFF with card_sel_no high. Chip select goes low before the first command's leading filler byte.
- R3: Each command is one 0xFF filler byte followed by a 6-byte frame: command byte 0x40|index, 4 argument bytes MSB first, then a CRC byte. The frames are reset 40 00 00 00 00 95, probe 48 00 00 01 AA 87, app-prefix 77 00 00 00 00 FF, read-OCR 7A 00 00 00 00 FF, and op-cond 69 xx 00 00 00 FF, where xx is 0x40 on the version-2 path and 0x00 on the version-1 path.
- R4: After a frame the sequencer polls with 0xFF bytes and takes the first received byte with bit 7 clear as R1. If POLL_LIMIT (default 256) polled bytes all have bit 7 set, the run ends with timeout_o, except after the probe.
- R5: After the reset command, an R1 with any bit of mask 0x7E set ends the run with not_ready_o.
- R6: If the probe times out or returns an R1 with a bit of 0x7E set, the version-1 path is taken. Otherwise 4 more bytes are read, and unless the third is 0x01 and the fourth is 0xAA the run ends with not_ready_o.
- R7: The app-prefix plus op-cond pair repeats while op-cond returns R1 = 0x01. R1 = 0x00 leaves the loop, and any other value gives not_ready_o. If ACMD41_TRIES (default 16) op-cond replies are all 0x01, the run ends with not_ready_o.
- R8: On the version-2 path, read-OCR is sent and 4 bytes are read. Bit 6 of the first byte is copied to block_addr_o. When it is 1, the block-length command is skipped.
- R9: On the byte-addressed path (version 1, or version 2 with that OCR bit clear), the block-length frame 50 00 00 02 00 FF is sent. Its R1 must be 0x00, otherwise not_ready_o. block_addr_o stays 0 on this path.
- R10: A successful run sends one last 0xFF with card_sel_no low, then raises card_sel_no and sets ready_o. A failed run raises card_sel_no with no further byte.
- R11: While a transfer is requested and not yet done, xfer_tx_o and xfer_req_o stay unchanged.
- R12: ready_o, not_ready_o and timeout_o are mutually exclusive and are cleared by an accepted start. xfer_req_o is only high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up run; acted on only while not busy |
| card_present_i | input | 1 | Card detect, high when a card is inserted |
| xfer_req_o | output | 1 | Byte transfer request to the SPI shifter |
| xfer_tx_o | output | 8 | Byte to shift out |
| xfer_rx_i | input | 8 | Byte shifted in, valid with xfer_done_i |
| xfer_done_i | input | 1 | One-cycle pulse ending the requested transfer |
| card_sel_no | output | 1 | Card chip select, active low |
| busy_o | output | 1 | Run in progress |
| ready_o | output | 1 | Card brought up |
| not_ready_o | output | 1 | Card absent, rejected a command or never left idle |
| timeout_o | output | 1 | A command response never arrived |
| block_addr_o | output | 1 | 1 when the card is sector addressed, 0 when byte addressed |

## Verification
The assertions assume the shifter answers each request with one done pulse, never pulses done without a request, and presents the received byte in the same cycle as done. Under those assumptions the held-transmit-byte and chip-select properties are meaningful. The bench stays within this contract with a behavioural card that latches each requested byte, waits a fixed latency, pulses done once, and ignores the request during the pulse cycle. That card decodes the frames it sees under chip select and answers from a per-scenario script, with optional filler delay before each R1.

// File: rtl/sd_seq_pkg.sv
`timescale 1ns/1ps
package sd_seq_pkg;
  typedef enum logic [2:0] {
    CMD_GO_IDLE, CMD_IF_COND, CMD_APP, CMD_OPC_V1, CMD_OPC_V2, CMD_READ_OCR, CMD_BLKLEN
  } sd_cmd_e;

  typedef enum logic {OP_FILL, OP_CMD} xfer_op_e;

  typedef enum logic [2:0] {E_IDLE, E_FILL, E_PRE, E_FRAME, E_POLL} eng_st_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE, S_GO_IDLE, S_IF_COND, S_IF_ECHO, S_APP, S_OPC,
    S_OCR_CMD, S_OCR_READ, S_BLKLEN, S_TAIL, S_END
  } ctl_st_e;

  typedef enum logic [1:0] {FAIL_NONE, FAIL_NR, FAIL_TMO} fail_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] R1_ILLEGAL_MASK = 8'h7E;
endpackage

// File: rtl/sd_frame_rom.sv
`timescale 1ns/1ps
module sd_frame_rom
  import sd_seq_pkg::*;
(
  input  sd_cmd_e    cmd_i,
  input  logic [2:0] idx_i,
  output logic [7:0] byte_o
);
  logic [5:0]  code;
  logic [31:0] arg;
  logic [7:0]  crc;
  logic [47:0] frame;

  always_comb begin
    code = 6'd0;
    arg  = 32'h0;
    crc  = 8'hFF;
    unique case (cmd_i)
      CMD_GO_IDLE:  begin code = 6'd0;  crc = 8'h95; end
      CMD_IF_COND:  begin code = 6'd8;  arg = 32'h0000_01AA; crc = 8'h87; end
      CMD_APP:      code = 6'd55;
      CMD_OPC_V1:   code = 6'd41;
      CMD_OPC_V2:   begin code = 6'd41; arg = 32'h4000_0000; end
      CMD_READ_OCR: code = 6'd58;
      CMD_BLKLEN:   begin code = 6'd16; arg = 32'h0000_0200; end
      default:      code = 6'd0;
    endcase
    frame = {2'b01, code, arg, crc};
  end

  always_comb begin
    unique case (idx_i)
      3'd0:    byte_o = frame[47:40];
      3'd1:    byte_o = frame[39:32];
      3'd2:    byte_o = frame[31:24];
      3'd3:    byte_o = frame[23:16];
      3'd4:    byte_o = frame[15:8];
      default: byte_o = frame[7:0];
    endcase
  end
endmodule

// File: rtl/sd_cmd_xfer.sv
`timescale 1ns/1ps
module sd_cmd_xfer
  import sd_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 256,
  parameter int FILL_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  xfer_op_e          op_i,
  input  sd_cmd_e           cmd_i,
  input  logic [FILL_W-1:0] fill_n_i,
  output logic              req_o,
  output logic [7:0]        tx_o,
  input  logic [7:0]        rx_i,
  input  logic              done_i,
  output logic              fin_o,
  output logic [7:0]        r1_o,
  output logic              tmo_o,
  output logic              lead_b6_o,
  output logic              echo_ok_o
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  eng_st_e           st_q;
  sd_cmd_e           cmd_q;
  logic [FILL_W-1:0] fill_n_q, byte_cnt_q;
  logic [2:0]        idx_q;
  logic [PW-1:0]     poll_cnt_q;
  logic [15:0]       tail_q;
  logic [7:0]        rom_byte;

  sd_frame_rom u_rom (.cmd_i(cmd_q), .idx_i(idx_q), .byte_o(rom_byte));

  assign req_o     = (st_q != E_IDLE);
  assign tx_o      = (st_q == E_FRAME) ? rom_byte : FILL_BYTE;
  assign echo_ok_o = (tail_q == 16'h01AA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= E_IDLE;
      cmd_q      <= CMD_GO_IDLE;
      fill_n_q   <= '0;
      byte_cnt_q <= '0;
      idx_q      <= '0;
      poll_cnt_q <= '0;
      tail_q     <= '0;
      lead_b6_o  <= 1'b0;
      r1_o       <= 8'hFF;
      tmo_o      <= 1'b0;
      fin_o      <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      unique case (st_q)
        E_IDLE: if (go_i) begin
          byte_cnt_q <= '0;
          idx_q      <= '0;
          poll_cnt_q <= '0;
          fill_n_q   <= fill_n_i;
          cmd_q      <= cmd_i;
          st_q       <= (op_i == OP_FILL) ? E_FILL : E_PRE;
        end
        E_FILL: if (done_i) begin
          tail_q <= {tail_q[7:0], rx_i};
          if (byte_cnt_q == '0) lead_b6_o <= rx_i[6];
          if (byte_cnt_q == fill_n_q - FILL_W'(1)) begin
            st_q  <= E_IDLE;
            fin_o <= 1'b1;
          end else begin
            byte_cnt_q <= byte_cnt_q + FILL_W'(1);
          end
        end
        E_PRE: if (done_i) st_q <= E_FRAME;
        E_FRAME: if (done_i) begin
          if (idx_q == 3'd5) st_q <= E_POLL;
          else idx_q <= idx_q + 3'd1;
        end
        E_POLL: if (done_i) begin
          if (!rx_i[7]) begin
            r1_o  <= rx_i;
            tmo_o <= 1'b0;
            fin_o <= 1'b1;
            st_q  <= E_IDLE;
          end else if (poll_cnt_q == POLL_LAST) begin
            r1_o  <= rx_i;
            tmo_o <= 1'b1;
            fin_o <= 1'b1;
            st_q  <= E_IDLE;
          end else begin
            poll_cnt_q <= poll_cnt_q + PW'(1);
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_init_ctrl.sv
`timescale 1ns/1ps
module sd_init_ctrl
  import sd_seq_pkg::*;
#(
  parameter int WAKE_BYTES   = 16,
  parameter int ACMD41_TRIES = 16,
  parameter int FILL_W       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              card_present_i,
  output logic              eng_go_o,
  output xfer_op_e          eng_op_o,
  output sd_cmd_e           eng_cmd_o,
  output logic [FILL_W-1:0] eng_fill_n_o,
  input  logic              eng_fin_i,
  input  logic [7:0]        eng_r1_i,
  input  logic              eng_tmo_i,
  input  logic              eng_lead_b6_i,
  input  logic              eng_echo_ok_i,
  output logic              card_sel_no,
  output logic              busy_o,
  output logic              ready_o,
  output logic              not_ready_o,
  output logic              timeout_o,
  output logic              block_addr_o
);
  localparam int TW = $clog2(ACMD41_TRIES + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(ACMD41_TRIES - 1);

  ctl_st_e       st_q, nxt_st;
  fail_e         nxt_fail;
  logic          pend_q, v2_q, nxt_v2, nxt_blk, try_inc, nxt_ok;
  logic [TW-1:0] tries_q;
  logic          active;

  assign active      = !(st_q inside {S_IDLE, S_END});
  assign busy_o      = active;
  assign card_sel_no = st_q inside {S_IDLE, S_WAKE, S_END};
  assign eng_go_o    = active && !pend_q;

  // per-step engine operation
  always_comb begin
    eng_op_o     = OP_CMD;
    eng_cmd_o    = CMD_GO_IDLE;
    eng_fill_n_o = FILL_W'(4);
    unique case (st_q)
      S_WAKE:     begin eng_op_o = OP_FILL; eng_fill_n_o = FILL_W'(WAKE_BYTES); end
      S_IF_ECHO,
      S_OCR_READ: eng_op_o = OP_FILL;
      S_TAIL:     begin eng_op_o = OP_FILL; eng_fill_n_o = FILL_W'(1); end
      S_IF_COND:  eng_cmd_o = CMD_IF_COND;
      S_APP:      eng_cmd_o = CMD_APP;
      S_OPC:      eng_cmd_o = v2_q ? CMD_OPC_V2 : CMD_OPC_V1;
      S_OCR_CMD:  eng_cmd_o = CMD_READ_OCR;
      S_BLKLEN:   eng_cmd_o = CMD_BLKLEN;
      default:    eng_cmd_o = CMD_GO_IDLE;
    endcase
  end

  // decision taken when the current step finishes
  always_comb begin
    nxt_st   = st_q;
    nxt_fail = FAIL_NONE;
    nxt_v2   = v2_q;
    nxt_blk  = 1'b0;
    nxt_ok   = 1'b0;
    try_inc  = 1'b0;
    unique case (st_q)
      S_WAKE: nxt_st = S_GO_IDLE;
      S_GO_IDLE:
        if (eng_tmo_i) nxt_fail = FAIL_TMO;
        else if ((eng_r1_i & R1_ILLEGAL_MASK) != 8'h0) nxt_fail = FAIL_NR;
        else nxt_st = S_IF_COND;
      S_IF_COND:
        if (eng_tmo_i || (eng_r1_i & R1_ILLEGAL_MASK) != 8'h0) nxt_st = S_APP;
        else nxt_st = S_IF_ECHO;
      S_IF_ECHO:
        if (eng_echo_ok_i) begin nxt_v2 = 1'b1; nxt_st = S_APP; end
        else nxt_fail = FAIL_NR;
      S_APP:
        if (eng_tmo_i) nxt_fail = FAIL_TMO;
        else if ((eng_r1_i & R1_ILLEGAL_MASK) != 8'h0) nxt_fail = FAIL_NR;
        else nxt_st = S_OPC;
      S_OPC:
        if (eng_tmo_i) nxt_fail = FAIL_TMO;
        else if (eng_r1_i == 8'h00) nxt_st = v2_q ? S_OCR_CMD : S_BLKLEN;
        else if (eng_r1_i == 8'h01 && tries_q != TRY_LAST) begin
          try_inc = 1'b1;
          nxt_st  = S_APP;
        end else nxt_fail = FAIL_NR;
      S_OCR_CMD:
        if (eng_tmo_i) nxt_fail = FAIL_TMO;
        else nxt_st = S_OCR_READ;
      S_OCR_READ: begin
        nxt_blk = eng_lead_b6_i;
        nxt_st  = eng_lead_b6_i ? S_TAIL : S_BLKLEN;
      end
      S_BLKLEN:
        if (eng_tmo_i) nxt_fail = FAIL_TMO;
        else if (eng_r1_i != 8'h00) nxt_fail = FAIL_NR;
        else nxt_st = S_TAIL;
      S_TAIL: begin nxt_ok = 1'b1; nxt_st = S_END; end
      default: nxt_st = st_q;
    endcase
    if (nxt_fail != FAIL_NONE) nxt_st = S_END;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      pend_q       <= 1'b0;
      v2_q         <= 1'b0;
      tries_q      <= '0;
      ready_o      <= 1'b0;
      not_ready_o  <= 1'b0;
      timeout_o    <= 1'b0;
      block_addr_o <= 1'b0;
    end else if (!active) begin
      if (start_i) begin
        pend_q       <= 1'b0;
        v2_q         <= 1'b0;
        tries_q      <= '0;
        ready_o      <= 1'b0;
        timeout_o    <= 1'b0;
        block_addr_o <= 1'b0;
        not_ready_o  <= !card_present_i;
        st_q         <= card_present_i ? S_WAKE : S_END;
      end
    end else if (!pend_q) begin
      pend_q <= 1'b1;
    end else if (eng_fin_i) begin
      pend_q <= 1'b0;
      st_q   <= nxt_st;
      v2_q   <= nxt_v2;
      if (try_inc) tries_q <= tries_q + TW'(1);
      if (nxt_blk) block_addr_o <= 1'b1;
      if (nxt_ok) ready_o <= 1'b1;
      if (nxt_fail == FAIL_NR) not_ready_o <= 1'b1;
      if (nxt_fail == FAIL_TMO) timeout_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sd_init_seq.sv
`timescale 1ns/1ps
module sd_init_seq
  import sd_seq_pkg::*;
#(
  parameter int WAKE_BYTES   = 16,
  parameter int POLL_LIMIT   = 256,
  parameter int ACMD41_TRIES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       card_present_i,
  output logic       xfer_req_o,
  output logic [7:0] xfer_tx_o,
  input  logic [7:0] xfer_rx_i,
  input  logic       xfer_done_i,
  output logic       card_sel_no,
  output logic       busy_o,
  output logic       ready_o,
  output logic       not_ready_o,
  output logic       timeout_o,
  output logic       block_addr_o
);
  localparam int WAKE_W = $clog2(WAKE_BYTES + 1);
  localparam int FILL_W = (WAKE_W > 3) ? WAKE_W : 3;

  logic              go, fin, tmo, lead_b6, echo_ok;
  xfer_op_e          op;
  sd_cmd_e           cmd;
  logic [FILL_W-1:0] fill_n;
  logic [7:0]        r1;

  sd_init_ctrl #(
    .WAKE_BYTES(WAKE_BYTES), .ACMD41_TRIES(ACMD41_TRIES), .FILL_W(FILL_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .card_present_i,
    .eng_go_o(go), .eng_op_o(op), .eng_cmd_o(cmd), .eng_fill_n_o(fill_n),
    .eng_fin_i(fin), .eng_r1_i(r1), .eng_tmo_i(tmo),
    .eng_lead_b6_i(lead_b6), .eng_echo_ok_i(echo_ok),
    .card_sel_no, .busy_o, .ready_o, .not_ready_o, .timeout_o, .block_addr_o
  );

  sd_cmd_xfer #(.POLL_LIMIT(POLL_LIMIT), .FILL_W(FILL_W)) u_xfer (
    .clk_i, .rst_ni, .go_i(go), .op_i(op), .cmd_i(cmd), .fill_n_i(fill_n),
    .req_o(xfer_req_o), .tx_o(xfer_tx_o), .rx_i(xfer_rx_i), .done_i(xfer_done_i),
    .fin_o(fin), .r1_o(r1), .tmo_o(tmo), .lead_b6_o(lead_b6), .echo_ok_o(echo_ok)
  );
endmodule

// File: rtl/sd_init_seq_chk.sv
`timescale 1ns/1ps
module sd_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       card_present_i,
  input logic       xfer_req_o,
  input logic [7:0] xfer_tx_o,
  input logic       xfer_done_i,
  input logic       card_sel_no,
  input logic       busy_o,
  input logic       ready_o,
  input logic       not_ready_o,
  input logic       timeout_o,
  input logic       block_addr_o
);
  assert_absent_nr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !card_present_i) |=> (not_ready_o && !busy_o && card_sel_no));

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_tx_o)));

  assert_status_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ready_o, not_ready_o, timeout_o}));

  assert_req_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> busy_o);

  assert_cs_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> card_sel_no);

  assert_blk_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_addr_o && !busy_o) |-> ready_o);
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
  .clk_i, .rst_ni, .start_i, .card_present_i, .xfer_req_o, .xfer_tx_o,
  .xfer_done_i, .card_sel_no, .busy_o, .ready_o, .not_ready_o, .timeout_o,
  .block_addr_o
);

// File: tb/sim_sd_init_seq.sv
`timescale 1ns/1ps
module sim_sd_init_seq;
  typedef struct packed {
    logic       present;
    logic [7:0] c0_r1;
    logic [1:0] c8_mode;   // 0 echo ok, 1 timeout, 2 illegal, 3 bad echo
    logic [7:0] busy;      // op-cond replies of 0x01 before the final one
    logic [7:0] a41_fin;
    logic       ccs;
    logic [7:0] c16_r1;
    logic [3:0] dly;
    logic       e_rdy, e_nr, e_tmo, e_blk;
    logic [7:0] e_frames;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h01, 2'd0, 8'd0,  8'h00, 1'b1, 8'h00, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5},
    '{1'b1, 8'h01, 2'd0, 8'd2,  8'h00, 1'b0, 8'h00, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10},
    '{1'b1, 8'h01, 2'd2, 8'd0,  8'h00, 1'b0, 8'h00, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
    '{1'b1, 8'h01, 2'd1, 8'd0,  8'h00, 1'b0, 8'h00, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd5},
    '{1'b1, 8'h01, 2'd3, 8'd0,  8'h00, 1'b1, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2},
    '{1'b1, 8'h03, 2'd0, 8'd0,  8'h00, 1'b1, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1},
    '{1'b1, 8'hFF, 2'd0, 8'd0,  8'h00, 1'b1, 8'h00, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1},
    '{1'b1, 8'h01, 2'd0, 8'd3,  8'h00, 1'b1, 8'h00, 4'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'd11},
    '{1'b1, 8'h01, 2'd0, 8'd20, 8'h00, 1'b1, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd34},
    '{1'b1, 8'h01, 2'd0, 8'd0,  8'h05, 1'b1, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4},
    '{1'b1, 8'h01, 2'd2, 8'd0,  8'h00, 1'b0, 8'h04, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},
    '{1'b1, 8'h01, 2'd0, 8'd15, 8'h00, 1'b1, 8'h00, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd35},
    '{1'b0, 8'h01, 2'd0, 8'd0,  8'h00, 1'b1, 8'h00, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0}
  };
  string vtag [NV] = '{"R8", "R9", "R6", "R6", "R6", "R5", "R4", "R7", "R7", "R7", "R9", "R7", "R1"};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       start = 1'b0, present = 1'b0;
  logic       xfer_req, xfer_done = 1'b0, card_sel_n;
  logic [7:0] xfer_tx, xfer_rx = 8'hFF;
  logic       busy, ready, not_ready, timeout, block_addr;

  sd_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .card_present_i(present),
    .xfer_req_o(xfer_req), .xfer_tx_o(xfer_tx), .xfer_rx_i(xfer_rx),
    .xfer_done_i(xfer_done), .card_sel_no(card_sel_n), .busy_o(busy),
    .ready_o(ready), .not_ready_o(not_ready), .timeout_o(timeout),
    .block_addr_o(block_addr)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural card
  localparam int LOGN = 1024;
  vec_t        cfg;
  logic [7:0]  log_tx [LOGN];
  logic        log_cs [LOGN];
  logic [47:0] frames [64];
  logic [7:0]  rq [32];
  int          ntx, nfr, rhead, rtail, fidx, a41_cnt, tx_slip = 0;
  logic [47:0] fbuf;
  logic        m_busy = 1'b0, m_csl;
  int          m_lat;
  logic [7:0]  m_txl, popped;

  task automatic push(input logic [7:0] b);
    rq[rtail % 32] = b;
    rtail++;
  endtask

  task automatic respond(input logic [5:0] code);
    for (int i = 0; i < int'(cfg.dly); i++) push(8'hFF);
    case (code)
      6'd0:  push(cfg.c0_r1);
      6'd8:  case (cfg.c8_mode)
               2'd0: begin push(8'h01); push(8'h00); push(8'h00); push(8'h01); push(8'hAA); end
               2'd2: push(8'h05);
               2'd3: begin push(8'h01); push(8'h00); push(8'h00); push(8'h01); push(8'h55); end
               default: ;
             endcase
      6'd55: push(8'h01);
      6'd41: begin
               a41_cnt++;
               push((a41_cnt <= int'(cfg.busy)) ? 8'h01 : cfg.a41_fin);
             end
      6'd58: begin push(8'h00); push(cfg.ccs ? 8'hC0 : 8'h80); push(8'hFF); push(8'h80); push(8'h00); end
      6'd16: push(cfg.c16_r1);
      default: ;
    endcase
  endtask

  task automatic take(input logic [7:0] b);
    if (fidx == 0) begin
      if (b[7:6] == 2'b01) begin fbuf = {b, 40'h0}; fidx = 1; end
    end else begin
      fbuf[47 - 8*fidx -: 8] = b;
      fidx++;
      if (fidx == 6) begin
        if (nfr < 64) frames[nfr] = fbuf;
        nfr++;
        fidx = 0;
        respond(fbuf[45:40]);
      end
    end
  endtask

  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (m_busy) begin
      if (m_lat != 0) m_lat--;
      else begin
        if (xfer_tx !== m_txl) tx_slip++;
        if (rhead != rtail) begin popped = rq[rhead % 32]; rhead++; end
        else popped = 8'hFF;
        xfer_rx   <= popped;
        xfer_done <= 1'b1;
        m_busy = 1'b0;
        if (ntx < LOGN) begin log_tx[ntx] = m_txl; log_cs[ntx] = m_csl; end
        ntx++;
        if (!m_csl) take(m_txl);
      end
    end else if (xfer_req && !xfer_done) begin
      m_busy = 1'b1;
      m_lat  = 1;
      m_txl  = xfer_tx;
      m_csl  = card_sel_n;
    end
  end

  task automatic arm(input int v);
    cfg = VECS[v];
    ntx = 0; nfr = 0; rhead = 0; rtail = 0; fidx = 0; a41_cnt = 0;
  endtask

  task automatic wait_idle();
    int w = 0;
    while (busy && w < 60000) begin @(negedge clk); w++; end
  endtask

  task automatic run(input int v);
    arm(v);
    @(negedge clk);
    present = cfg.present;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R10 reset cs", card_sel_n, 1);
    chk("R12 reset req", xfer_req, 0);
    chk("R12 reset status", {ready, not_ready, timeout, block_addr}, 0);

    for (int v = 0; v < NV; v++) begin
      run(v);
      chk({vtag[v], " ready"}, ready, VECS[v].e_rdy);
      chk({vtag[v], " not_ready"}, not_ready, VECS[v].e_nr);
      chk({vtag[v], " timeout"}, timeout, VECS[v].e_tmo);
      chk({vtag[v], " block_addr"}, block_addr, VECS[v].e_blk);
      chk({vtag[v], " frame count"}, nfr, VECS[v].e_frames);
    end

    // R1: absent card, no traffic
    run(12);
    chk("R1 no transfers", ntx, 0);
    chk("R1 cs high", card_sel_n, 1);

    // R2/R3/R10: nominal sector-addressed run
    run(0);
    begin
      logic ok = 1'b1;
      for (int i = 0; i < 16; i++) if (log_tx[i] !== 8'hFF || log_cs[i] !== 1'b1) ok = 1'b0;
      chk("R2 wake bytes", ok, 1);
    end
    chk("R2 cs low at first filler", {log_cs[16], log_tx[16]}, {1'b0, 8'hFF});
    chk("R3 reset frame", frames[0], 48'h40_0000_0000_95);
    chk("R3 probe frame", frames[1], 48'h48_0000_01AA_87);
    chk("R3 app frame", frames[2], 48'h77_0000_0000_FF);
    chk("R3 v2 op-cond frame", frames[3], 48'h69_4000_0000_FF);
    chk("R8 ocr frame", frames[4], 48'h7A_0000_0000_FF);
    chk("R10 last byte", {log_cs[ntx-1], log_tx[ntx-1]}, {1'b0, 8'hFF});
    chk("R10 cs released", card_sel_n, 1);

    // R3/R9: version-1 path
    run(2);
    chk("R3 v1 op-cond frame", frames[3], 48'h69_0000_0000_FF);
    chk("R9 block length frame", frames[4], 48'h50_0000_0200_FF);

    // R4: exact poll budget
    run(6);
    chk("R4 poll count", ntx, 16 + 1 + 6 + 256);

    // R10: failure releases cs without extra byte; R12: start clears status
    run(5);
    chk("R10 no tail on failure", ntx, 24);
    arm(0);
    present = 1'b1;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 start clears", {busy, not_ready, ready, timeout}, 4'b1000);
    wait_idle();
    @(negedge clk);
    chk("R12 rerun ready", ready, 1);

    chk("R11 tx held during transfer", tx_slip, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule